// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

A purely combinational execution unit for the base bit-manipulation group of a 32-bit RISC-V core. Each cycle it receives the raw instruction word and the two source operand values already read from the register file. It decodes the opcode, funct3, funct7 and the rs2 field, and returns a result word together with a flag telling the pipeline whether the instruction belongs to this unit.

The covered work spans several kinds of operation:

- bit counting: leading zeros, trailing zeros and set bits;
- narrowing extensions;
- signed and unsigned minimum and maximum;
- logic operations with an inverted second operand;
- rotates by a register amount or by an immediate amount;
- a per-byte "any bit set" mask;
- a byte-order swap.

The surrounding pipeline routes the result to write-back only when the flag is high. Register access, pipelining, hazards and exceptions are handled elsewhere.

Top module: `bitmanip_alu`

## Requirements
- R1: opcode 0010011, funct7 0110000, funct3 001, rs2 field 00000 returns the number of leading zeros of rs_a. An all-zero operand yields 32.
- R2: the same encoding with rs2 field 00001 returns the number of trailing zeros of rs_a. An all-zero operand yields 32.
- R3: the same encoding with rs2 field 00010 returns the count of set bits of rs_a. An all-ones operand yields 32.
- R4: the same encoding with rs2 field 00100 replicates bit 7 into bits 31:8. With rs2 field 00101 it replicates bit 15 into bits 31:16.
- R5: opcode 0110011, funct7 0000100, funct3 100, rs2 field 00000 returns rs_a with bits 31:16 cleared.
- R6: opcode 0110011, funct7 0000101 returns the signed minimum for funct3 100 and the signed maximum for funct3 110.
- R7: opcode 0110011, funct7 0000101 returns the unsigned minimum for funct3 101 and the unsigned maximum for funct3 111.
- R8: opcode 0110011, funct7 0100000 returns a AND NOT b for funct3 111, a OR NOT b for funct3 110, and a XOR NOT b for funct3 100.
- R9: opcode 0110011, funct7 0110000 rotates rs_a left for funct3 001 and right for funct3 101. The amount is rs_b[4:0]; rs_b[31:5] has no effect. An amount of zero returns rs_a unchanged.
- R10: opcode 0010011, funct7 0110000, funct3 101 rotates rs_a right by the instruction's bits 24:20.
- R11: opcode 0010011, funct7 0010100, rs2 field 00111, funct3 101 sets each result byte to 0xFF where the matching byte of rs_a is nonzero, and to 0x00 elsewhere.
- R12: opcode 0010011, funct7 0110100, rs2 field 11000, funct3 101 reverses the byte order of rs_a, so byte 0 goes to byte 3, byte 1 to byte 2, and so on.
- R13: every listed encoding raises match. Every other instruction word drives match low and the result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word |
| rs_a_i | input | XLEN | First source operand value |
| rs_b_i | input | XLEN | Second source operand value |
| result_o | output | XLEN | Operation result, zero when match_o is low |
| match_o | output | 1 | Instruction belongs to this unit |

## Verification
Random instruction words almost never land on a valid encoding. The near misses are the hardest cases to reach: a unary word whose rs2 field is not one of the five defined codes, a byte-mask or byte-swap word with one rs2 bit wrong, or funct7 0000101 with funct3 below 100. The stimulus therefore builds words from the valid field tuples and then mutates single fields for a share of the vectors. A separate group of operands hits zero, all ones and single set bits, so the counters see their extreme values.

// File: rtl/bitmanip_alu.sv
module bitmanip_alu #(
  parameter int XLEN = 32
) (
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] rs_a_i,
  input  logic [XLEN-1:0] rs_b_i,
  output logic [XLEN-1:0] result_o,
  output logic            match_o
);

  localparam int SHW   = $clog2(XLEN);
  localparam int CNTW  = SHW + 1;
  localparam int NBYTE = XLEN / 8;

  localparam logic [6:0] OPC_IMM = 7'b0010011;
  localparam logic [6:0] OPC_REG = 7'b0110011;

  typedef enum logic [4:0] {
    K_NONE, K_CLZ, K_CTZ, K_CPOP, K_SEXTB, K_SEXTH, K_ZEXTH,
    K_MIN, K_MINU, K_MAX, K_MAXU, K_ANDN, K_ORN, K_XNOR,
    K_ROL, K_ROR, K_RORI, K_ORCB, K_REV8
  } kind_e;

  logic [6:0] opc, f7;
  logic [2:0] f3;
  logic [4:0] sel;

  assign opc = insn_i[6:0];
  assign f3  = insn_i[14:12];
  assign sel = insn_i[24:20];
  assign f7  = insn_i[31:25];

  kind_e kind;

  always_comb begin
    kind = K_NONE;
    if (opc == OPC_IMM) begin
      if (f7 == 7'b0110000 && f3 == 3'b001) begin
        case (sel)
          5'b00000: kind = K_CLZ;
          5'b00001: kind = K_CTZ;
          5'b00010: kind = K_CPOP;
          5'b00100: kind = K_SEXTB;
          5'b00101: kind = K_SEXTH;
          default:  kind = K_NONE;
        endcase
      end else if (f3 == 3'b101) begin
        if (f7 == 7'b0110000)                      kind = K_RORI;
        else if (f7 == 7'b0010100 && sel == 5'b00111) kind = K_ORCB;
        else if (f7 == 7'b0110100 && sel == 5'b11000) kind = K_REV8;
      end
    end else if (opc == OPC_REG) begin
      case (f7)
        7'b0000100: if (f3 == 3'b100 && sel == 5'b00000) kind = K_ZEXTH;
        7'b0000101:
          case (f3)
            3'b100:  kind = K_MIN;
            3'b101:  kind = K_MINU;
            3'b110:  kind = K_MAX;
            3'b111:  kind = K_MAXU;
            default: kind = K_NONE;
          endcase
        7'b0100000:
          case (f3)
            3'b111:  kind = K_ANDN;
            3'b110:  kind = K_ORN;
            3'b100:  kind = K_XNOR;
            default: kind = K_NONE;
          endcase
        7'b0110000:
          case (f3)
            3'b001:  kind = K_ROL;
            3'b101:  kind = K_ROR;
            default: kind = K_NONE;
          endcase
        default: kind = K_NONE;
      endcase
    end
  end

  logic [CNTW-1:0] n_lead, n_trail, n_ones;

  always_comb begin
    logic hit_hi, hit_lo;
    n_lead  = '0;
    n_trail = '0;
    n_ones  = '0;
    hit_hi  = 1'b0;
    hit_lo  = 1'b0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (rs_a_i[i]) hit_hi = 1'b1;
      else if (!hit_hi) n_lead = n_lead + 1'b1;
    end
    for (int i = 0; i < XLEN; i++) begin
      if (rs_a_i[i]) hit_lo = 1'b1;
      else if (!hit_lo) n_trail = n_trail + 1'b1;
      n_ones = n_ones + CNTW'(rs_a_i[i]);
    end
  end

  logic [SHW-1:0]    amt;
  logic [2*XLEN-1:0] rot_l, rot_r;

  assign amt   = (kind == K_RORI) ? insn_i[20 +: SHW] : rs_b_i[SHW-1:0];
  assign rot_l = {rs_a_i, rs_a_i} << amt;
  assign rot_r = {rs_a_i, rs_a_i} >> amt;

  logic [XLEN-1:0] byte_mask, byte_swap;

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    assign byte_mask[g*8 +: 8] = {8{|rs_a_i[g*8 +: 8]}};
    assign byte_swap[g*8 +: 8] = rs_a_i[(NBYTE-1-g)*8 +: 8];
  end

  logic s_lt, u_lt;

  assign s_lt = $signed(rs_a_i) < $signed(rs_b_i);
  assign u_lt = rs_a_i < rs_b_i;

  always_comb begin
    case (kind)
      K_CLZ:   result_o = XLEN'(n_lead);
      K_CTZ:   result_o = XLEN'(n_trail);
      K_CPOP:  result_o = XLEN'(n_ones);
      K_SEXTB: result_o = {{(XLEN-8){rs_a_i[7]}}, rs_a_i[7:0]};
      K_SEXTH: result_o = {{(XLEN-16){rs_a_i[15]}}, rs_a_i[15:0]};
      K_ZEXTH: result_o = {{(XLEN-16){1'b0}}, rs_a_i[15:0]};
      K_MIN:   result_o = s_lt ? rs_a_i : rs_b_i;
      K_MAX:   result_o = s_lt ? rs_b_i : rs_a_i;
      K_MINU:  result_o = u_lt ? rs_a_i : rs_b_i;
      K_MAXU:  result_o = u_lt ? rs_b_i : rs_a_i;
      K_ANDN:  result_o = rs_a_i & ~rs_b_i;
      K_ORN:   result_o = rs_a_i | ~rs_b_i;
      K_XNOR:  result_o = rs_a_i ^ ~rs_b_i;
      K_ROL:   result_o = rot_l[2*XLEN-1:XLEN];
      K_ROR,
      K_RORI:  result_o = rot_r[XLEN-1:0];
      K_ORCB:  result_o = byte_mask;
      K_REV8:  result_o = byte_swap;
      default: result_o = '0;
    endcase
  end

  assign match_o = (kind != K_NONE);

endmodule

// File: rtl/bitmanip_alu_chk.sv
module bitmanip_alu_chk #(
  parameter int XLEN = 32
) (
  input logic [31:0]     insn_i,
  input logic [XLEN-1:0] rs_a_i,
  input logic [XLEN-1:0] rs_b_i,
  input logic [XLEN-1:0] result_o,
  input logic            match_o
);

  logic is_unary, is_mm, is_orcb, is_rol;

  assign is_unary = insn_i[6:0] == 7'b0010011 && insn_i[31:25] == 7'b0110000 &&
                    insn_i[14:12] == 3'b001;
  assign is_mm    = insn_i[6:0] == 7'b0110011 && insn_i[31:25] == 7'b0000101 && insn_i[14];
  assign is_orcb  = insn_i[6:0] == 7'b0010011 && insn_i[31:25] == 7'b0010100 &&
                    insn_i[14:12] == 3'b101 && insn_i[24:20] == 5'b00111;
  assign is_rol   = insn_i[6:0] == 7'b0110011 && insn_i[31:25] == 7'b0110000 &&
                    insn_i[14:12] == 3'b001;

  always_comb begin
    // R13
    unmatched_zero_chk: assert (match_o || result_o == '0);
    // R1
    count_range_chk: assert (!(is_unary && insn_i[24:20] == 5'b00000) || result_o <= XLEN);
    // R6
    minmax_pick_chk: assert (!is_mm || (match_o && (result_o == rs_a_i || result_o == rs_b_i)));
    // R11
    byte_mask_chk: assert (!is_orcb || ((result_o[7:0] == 8'h00 || result_o[7:0] == 8'hFF) &&
                                         (result_o[15:8] == 8'h00 || result_o[15:8] == 8'hFF)));
    // R9
    zero_rotate_chk: assert (!(is_rol && rs_b_i[4:0] == 5'd0) || result_o == rs_a_i);
    // R4
    sign_fill_chk: assert (!(is_unary && insn_i[24:20] == 5'b00100) ||
                           result_o[XLEN-1:8] == {(XLEN-8){result_o[7]}});
  end

endmodule

bind bitmanip_alu bitmanip_alu_chk #(.XLEN(XLEN)) u_chk (
  .insn_i(insn_i), .rs_a_i(rs_a_i), .rs_b_i(rs_b_i),
  .result_o(result_o), .match_o(match_o)
);

// File: tb/bitmanip_alu_bench.sv
module bitmanip_alu_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] insn, a, b, res;
  logic        hit;
  int n_vec = 0, n_bad = 0;

  bitmanip_alu #(.XLEN(32)) u_bitmanip_alu (
    .insn_i(insn), .rs_a_i(a), .rs_b_i(b), .result_o(res), .match_o(hit)
  );

  function automatic logic [31:0] mk(logic [6:0] f7, logic [4:0] r2, logic [2:0] f3, logic [6:0] op);
    return {f7, r2, 5'd3, f3, 5'd7, op};
  endfunction

  function automatic logic [31:0] rotr(logic [31:0] v, int n);
    logic [31:0] t = v;
    for (int k = 0; k < n; k++) t = {t[0], t[31:1]};
    return t;
  endfunction

  function automatic logic [32:0] model(logic [31:0] w, logic [31:0] x, logic [31:0] y);
    logic [6:0] op = w[6:0];
    logic [6:0] f7 = w[31:25];
    logic [2:0] f3 = w[14:12];
    logic [4:0] r2 = w[24:20];
    int c;
    if (op == 7'h13 && f7 == 7'h30 && f3 == 3'd1) begin
      c = 0;
      if (r2 == 5'd0) begin while (c < 32 && !x[31-c]) c++; return {1'b1, 32'(c)}; end
      if (r2 == 5'd1) begin while (c < 32 && !x[c]) c++; return {1'b1, 32'(c)}; end
      if (r2 == 5'd2) begin for (int k = 0; k < 32; k++) c += int'(x[k]); return {1'b1, 32'(c)}; end
      if (r2 == 5'd4) return {1'b1, (x[7] ? 24'hFFFFFF : 24'h0), x[7:0]};
      if (r2 == 5'd5) return {1'b1, (x[15] ? 16'hFFFF : 16'h0), x[15:0]};
    end
    if (op == 7'h13 && f3 == 3'd5) begin
      if (f7 == 7'h30) return {1'b1, rotr(x, int'(r2))};
      if (f7 == 7'h14 && r2 == 5'd7)
        return {1'b1, (x[31:24] != 0 ? 8'hFF : 8'h0), (x[23:16] != 0 ? 8'hFF : 8'h0),
                      (x[15:8] != 0 ? 8'hFF : 8'h0), (x[7:0] != 0 ? 8'hFF : 8'h0)};
      if (f7 == 7'h34 && r2 == 5'd24) return {1'b1, x[7:0], x[15:8], x[23:16], x[31:24]};
    end
    if (op == 7'h33) begin
      if (f7 == 7'h04 && f3 == 3'd4 && r2 == 5'd0) return {1'b1, 16'h0, x[15:0]};
      if (f7 == 7'h05) begin
        if (f3 == 3'd4) return {1'b1, (int'(x) < int'(y)) ? x : y};
        if (f3 == 3'd6) return {1'b1, (int'(x) < int'(y)) ? y : x};
        if (f3 == 3'd5) return {1'b1, (x < y) ? x : y};
        if (f3 == 3'd7) return {1'b1, (x < y) ? y : x};
      end
      if (f7 == 7'h20) begin
        if (f3 == 3'd7) return {1'b1, x & ~y};
        if (f3 == 3'd6) return {1'b1, x | ~y};
        if (f3 == 3'd4) return {1'b1, ~(x ^ y)};
      end
      if (f7 == 7'h30) begin
        if (f3 == 3'd1) return {1'b1, rotr(x, (32 - int'(y[4:0])) % 32)};
        if (f3 == 3'd5) return {1'b1, rotr(x, int'(y[4:0]))};
      end
    end
    return 33'd0;
  endfunction

  task automatic apply(string req, logic [31:0] w, logic [31:0] x, logic [31:0] y);
    logic [32:0] exp;
    @(negedge clk);
    insn = w; a = x; b = y;
    #1;
    exp = model(w, x, y);
    n_vec++;
    if ({hit, res} !== exp) begin
      n_bad++;
      $display("FAIL %s insn=%h a=%h b=%h got match=%b res=%h exp match=%b res=%h",
               req, w, x, y, hit, res, exp[32], exp[31:0]);
    end
  endtask

  task automatic expect_val(string req, logic [31:0] w, logic [31:0] x, logic [31:0] y,
                            logic ex_hit, logic [31:0] ex_res);
    @(negedge clk);
    insn = w; a = x; b = y;
    #1;
    n_vec++;
    if (hit !== ex_hit || res !== ex_res) begin
      n_bad++;
      $display("FAIL %s got match=%b res=%h exp match=%b res=%h", req, hit, res, ex_hit, ex_res);
    end
  endtask

  function automatic logic [31:0] pick_op();
    case ($urandom % 6)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h1 << ($urandom % 32);
      3: return $urandom & 32'hFF00_FF00;
      4: return {$urandom} & 32'h0000_FFFF;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [31:0] pick_insn();
    logic [31:0] w;
    case ($urandom % 19)
      0:  w = mk(7'h30, 5'd0, 3'd1, 7'h13);
      1:  w = mk(7'h30, 5'd1, 3'd1, 7'h13);
      2:  w = mk(7'h30, 5'd2, 3'd1, 7'h13);
      3:  w = mk(7'h30, 5'd4, 3'd1, 7'h13);
      4:  w = mk(7'h30, 5'd5, 3'd1, 7'h13);
      5:  w = mk(7'h04, 5'd0, 3'd4, 7'h33);
      6:  w = mk(7'h05, 5'($urandom), 3'(4 + $urandom % 4), 7'h33);
      7:  w = mk(7'h20, 5'($urandom), 3'd7, 7'h33);
      8:  w = mk(7'h20, 5'($urandom), 3'd6, 7'h33);
      9:  w = mk(7'h20, 5'($urandom), 3'd4, 7'h33);
      10: w = mk(7'h30, 5'($urandom), 3'd1, 7'h33);
      11: w = mk(7'h30, 5'($urandom), 3'd5, 7'h33);
      12: w = mk(7'h30, 5'($urandom), 3'd5, 7'h13);
      13: w = mk(7'h14, 5'd7, 3'd5, 7'h13);
      14: w = mk(7'h34, 5'd24, 3'd5, 7'h13);
      15: w = $urandom;
      default: w = mk(7'h30, 5'd0, 3'd1, 7'h13);
    endcase
    if ($urandom % 4 == 0) w ^= 32'h1 << ($urandom % 32);
    return w;
  endfunction

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    insn = 0; a = 0; b = 0;
    // R13 idle word gives no match and zero result
    expect_val("R13", 32'h0, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0, 32'h0);
    // R1 / R2 / R3 extremes
    expect_val("R1", mk(7'h30, 5'd0, 3'd1, 7'h13), 32'h0, 32'h0, 1'b1, 32'd32);
    expect_val("R1", mk(7'h30, 5'd0, 3'd1, 7'h13), 32'h0001_0000, 32'h0, 1'b1, 32'd15);
    expect_val("R2", mk(7'h30, 5'd1, 3'd1, 7'h13), 32'h0, 32'h0, 1'b1, 32'd32);
    expect_val("R2", mk(7'h30, 5'd1, 3'd1, 7'h13), 32'h8000_0000, 32'h0, 1'b1, 32'd31);
    expect_val("R3", mk(7'h30, 5'd2, 3'd1, 7'h13), 32'hFFFF_FFFF, 32'h0, 1'b1, 32'd32);
    // R4 sign extension
    expect_val("R4", mk(7'h30, 5'd4, 3'd1, 7'h13), 32'h1234_5680, 32'h0, 1'b1, 32'hFFFF_FF80);
    expect_val("R4", mk(7'h30, 5'd5, 3'd1, 7'h13), 32'hFFFF_7FFF, 32'h0, 1'b1, 32'h0000_7FFF);
    // R5 zero extension
    expect_val("R5", mk(7'h04, 5'd0, 3'd4, 7'h33), 32'hABCD_8001, 32'h0, 1'b1, 32'h0000_8001);
    // R6 signed vs R7 unsigned on mixed signs
    expect_val("R6", mk(7'h05, 5'd2, 3'd4, 7'h33), 32'hFFFF_FFFF, 32'h1, 1'b1, 32'hFFFF_FFFF);
    expect_val("R6", mk(7'h05, 5'd2, 3'd6, 7'h33), 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 32'h7FFF_FFFF);
    expect_val("R7", mk(7'h05, 5'd2, 3'd5, 7'h33), 32'hFFFF_FFFF, 32'h1, 1'b1, 32'h1);
    expect_val("R7", mk(7'h05, 5'd2, 3'd7, 7'h33), 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 32'h8000_0000);
    // R8 inverted-operand logic
    expect_val("R8", mk(7'h20, 5'd2, 3'd7, 7'h33), 32'hFF00_FF00, 32'h0F0F_0F0F, 1'b1, 32'hF000_F000);
    expect_val("R8", mk(7'h20, 5'd2, 3'd4, 7'h33), 32'hFF00_FF00, 32'h0F0F_0F0F, 1'b1, 32'h0FF0_0FF0);
    // R9 rotate, upper amount bits ignored, zero amount
    expect_val("R9", mk(7'h30, 5'd2, 3'd1, 7'h33), 32'h8000_0001, 32'hFFFF_FFE1, 1'b1, 32'h0000_0003);
    expect_val("R9", mk(7'h30, 5'd2, 3'd5, 7'h33), 32'h1234_5678, 32'h0000_0020, 1'b1, 32'h1234_5678);
    expect_val("R9", mk(7'h30, 5'd2, 3'd5, 7'h33), 32'h0000_0001, 32'h0000_0004, 1'b1, 32'h1000_0000);
    // R10 immediate rotate takes the amount from the word
    expect_val("R10", mk(7'h30, 5'd20, 3'd5, 7'h13), 32'h0010_0000, 32'h0000_0003, 1'b1, 32'h0000_0001);
    // R11 byte mask
    expect_val("R11", mk(7'h14, 5'd7, 3'd5, 7'h13), 32'h0080_0001, 32'h0, 1'b1, 32'h00FF_00FF);
    // R12 byte swap
    expect_val("R12", mk(7'h34, 5'd24, 3'd5, 7'h13), 32'h1122_3344, 32'h0, 1'b1, 32'h4433_2211);
    // R13 near misses
    expect_val("R13", mk(7'h30, 5'd3, 3'd1, 7'h13), 32'hFFFF_FFFF, 32'h1, 1'b0, 32'h0);
    expect_val("R13", mk(7'h05, 5'd2, 3'd1, 7'h33), 32'hFFFF_FFFF, 32'h3, 1'b0, 32'h0);
    expect_val("R13", mk(7'h34, 5'd25, 3'd5, 7'h13), 32'h1122_3344, 32'h0, 1'b0, 32'h0);
    expect_val("R13", mk(7'h04, 5'd1, 3'd4, 7'h33), 32'h1122_3344, 32'h0, 1'b0, 32'h0);
    // random mix covering R1..R13
    for (int i = 0; i < 4000; i++) apply("R1-mix", pick_insn(), pick_op(), pick_op());
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule